// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single down-counting channel of a legacy interval timer. A host-side register block hands it a 3-bit mode, a decimal/binary select and a reload value. It also hands it two strobes: one marks that the mode was programmed and one marks that a new count was written. The channel advances only on clock-enable cycles (`tick`) of a fixed-rate time base. It watches a `gate` input and drives one output pin `out`.

Six behaviours share one counter. There is a one-shot timeout, a gate-triggered one-shot, a rate generator and a square-wave generator. There are also a software-started strobe and a gate-started strobe. Counting runs in plain binary or in four-digit packed BCD. The live count and a `loaded` flag are brought out so that the host side can build readback on top of them. Port decoding, byte sequencing and readback latching are left to the host side.

A new count moves into the counter on the first `tick` after it is written (the "load tick"). The gate-triggered modes are the exception: there the load happens on the first `tick` after a rising gate edge. A strobe cycle (`mode_wr` or `cnt_wr`) performs no counting on that cycle. A reload value of 1 is not supported in the rate and square modes.

Top module: `pit_channel`

## Requirements
- R1: Mode 0 (`mode_sel`=0): `out` goes low when the mode is programmed or a count is written. With reload N, `out` rises on tick N+1 counting the load tick as tick 1, and then stays high. Decrementing happens only on ticks with `gate` high.
- R2: Mode 1: `out` idles high and nothing counts until a rising `gate` edge. The next tick loads N and drives `out` low, and `out` returns high N ticks later. Lowering `gate` does not stop this countdown. A later rising edge restarts the countdown from N.
- R3: Mode 2: after the load tick, `out` is low on every tick k (counting the load tick as 1) with k mod N = 0, and high otherwise; the counter reloads itself. While `gate` is low the count holds and `out` is forced high from the next clock.
- R4: Mode 3: `out` starts high at the load tick, the counter steps down by 2 per tick and reloads itself. Over each period of N ticks, `out` is high for (N+1)/2 ticks and low for N/2 ticks, using integer division.
- R5: Mode 4: `out` stays high. It drops low for exactly one tick on tick N+1, counting the load tick as 1. It does not pulse again until a new count is written.
- R6: Mode 5: `out` stays high until a rising `gate` edge. The following tick loads N. `out` is then low for one tick on the Nth tick after the load, even if `gate` falls in the meantime.
- R7: With `bcd_sel`=1 the count is four packed BCD digits and decrements in decimal, so 0x0100 steps to 0x0099.
- R8: Mode codes 6 and 7 behave exactly as modes 2 and 3.
- R9: A reload value of 0 means 65536 counts in binary and 10000 counts in BCD. The count after 0 is 0xFFFF in binary and 0x9999 in BCD.
- R10: In modes 0 and 4 a new count written while running restarts the countdown on the next tick. In mode 2 it takes effect only at the next automatic reload.
- R11: After reset, and after every mode write, `loaded` is 0. It stays 0 until the first count is transferred into the counter (the load tick, or in modes 1 and 5 the trigger tick), and then becomes 1.
- R12: On cycles without `tick`, `mode_wr` or `cnt_wr`, the count does not change. After reset the count is 0 and `out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counting clock enable |
| gate | input | 1 | Gate input |
| mode_wr | input | 1 | Mode programming strobe |
| mode_sel | input | 3 | Counting mode code 0..7 |
| bcd_sel | input | 1 | 1 = BCD counting, 0 = binary |
| cnt_wr | input | 1 | Count written strobe |
| cnt_val | input | CW (16) | Reload value |
| count | output | CW (16) | Live counter value |
| out | output | 1 | Channel output pin |
| loaded | output | 1 | A count has been transferred since the last mode write |

## Verification
The bench builds the channel with the default width of 16 bits, which makes the counter four BCD digits wide. At that width, the full 65536-count and 10000-count terminal cases of a zero reload fit inside one run. The rollover values 0xFFFF and 0x9999 can be observed directly. Random reload values are kept small, so that whole rate and square-wave periods fit into short sampled traces. Those traces cover odd and even split periods as well as decimal borrows across digits.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [2:0] {
    PM_TIMEOUT  = 3'd0,
    PM_TRIG_ONE = 3'd1,
    PM_RATE     = 3'd2,
    PM_SQUARE   = 3'd3,
    PM_SW_STRB  = 3'd4,
    PM_HW_STRB  = 3'd5
  } pit_mode_e;
endpackage

// File: rtl/pit_mode_norm.sv
module pit_mode_norm
  import pit_pkg::*;
(
  input  logic [2:0] sel,
  output pit_mode_e  mode
);
  // codes 6 and 7 fold onto the rate and square behaviours (R8)
  always_comb begin
    case (sel)
      3'd6:    mode = PM_RATE;
      3'd7:    mode = PM_SQUARE;
      default: mode = pit_mode_e'(sel);
    endcase
  end
endmodule

// File: rtl/pit_step_dec.sv
module pit_step_dec #(
  parameter int CW = 16
) (
  input  logic [CW-1:0] val,
  input  logic          bcd,
  input  logic          two,
  output logic [CW-1:0] res
);
  localparam int NDIG = CW / 4;

  logic [CW-1:0] bin_res;
  logic [CW-1:0] bcd_res;

  assign bin_res = val - {{(CW-2){1'b0}}, two, ~two};

  // digit-serial decimal subtract; the borrow is the sign bit of each digit
  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    logic [4:0] d;
    logic [4:0] s;
    logic [4:0] diff;
    assign d = {1'b0, val[4*i +: 4]};
    if (i == 0) begin : g_lsd
      assign s = {3'b000, two, ~two};
    end else begin : g_up
      assign s = {4'b0000, g_dig[i-1].diff[4]};
    end
    assign diff = d - s;
    assign bcd_res[4*i +: 4] = diff[4] ? (diff[3:0] + 4'd10) : diff[3:0];
  end

  assign res = bcd ? bcd_res : bin_res;
endmodule

// File: rtl/pit_gate_edge.sv
module pit_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  input  logic consume,
  input  logic clear,
  output logic trig
);
  logic gate_q;
  logic pend_q;
  logic pend_n;

  assign trig = pend_q | (gate & ~gate_q);

  always_comb begin
    pend_n = trig;
    if (consume || clear) pend_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      gate_q <= gate;
      pend_q <= pend_n;
    end
  end

  // an unconsumed rising edge must remain visible on the next cycle
  assert_edge_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && !gate_q && !consume && !clear) |=> trig);
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          gate,
  input  logic          mode_wr,
  input  logic [2:0]    mode_sel,
  input  logic          bcd_sel,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_val,
  output logic [CW-1:0] count,
  output logic          out,
  output logic          loaded
);
  localparam logic [CW-1:0] C_ONE = CW'(1);
  localparam logic [CW-1:0] C_TWO = CW'(2);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  pit_mode_e     mode_q, mode_n, mode_in;
  logic          bcd_q, bcd_n;
  logic [CW-1:0] rl_q, rl_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          out_q, out_n;
  logic          ld_q, ld_n;
  logic          have_q, have_n;
  logic          pend_q, pend_n;
  logic          done_q, done_n;
  logic [CW-1:0] dec1, dec2, rl_even;
  logic          trig, run_tick, last_sq;

  assign run_tick = tick && !mode_wr && !cnt_wr;
  assign rl_even  = {rl_q[CW-1:1], 1'b0};

  pit_mode_norm u_norm (.sel(mode_sel), .mode(mode_in));

  pit_gate_edge u_edge (
    .clk(clk), .rst_n(rst_s_n), .gate(gate),
    .consume(run_tick), .clear(mode_wr), .trig(trig)
  );

  pit_step_dec #(.CW(CW)) u_dec1 (.val(cnt_q), .bcd(bcd_q), .two(1'b0), .res(dec1));
  pit_step_dec #(.CW(CW)) u_dec2 (.val(cnt_q), .bcd(bcd_q), .two(1'b1), .res(dec2));

  // odd square-wave counts spend one extra tick in the high half
  assign last_sq = (rl_q[0] && out_q) ? (cnt_q == '0) : (cnt_q == C_TWO);

  always_comb begin
    mode_n = mode_q;
    bcd_n  = bcd_q;
    rl_n   = rl_q;
    cnt_n  = cnt_q;
    out_n  = out_q;
    ld_n   = ld_q;
    have_n = have_q;
    pend_n = pend_q;
    done_n = done_q;
    if (mode_wr) begin
      mode_n = mode_in;
      bcd_n  = bcd_sel;
      out_n  = (mode_in != PM_TIMEOUT);
      ld_n   = 1'b0;
      have_n = 1'b0;
      pend_n = 1'b0;
      done_n = 1'b0;
    end else if (cnt_wr) begin
      rl_n   = cnt_val;
      have_n = 1'b1;
      if (mode_q == PM_TIMEOUT) out_n = 1'b0;
      if (mode_q == PM_TIMEOUT || mode_q == PM_SW_STRB ||
          ((mode_q == PM_RATE || mode_q == PM_SQUARE) && !ld_q))
        pend_n = 1'b1;
    end else if (tick) begin
      case (mode_q)
        PM_TIMEOUT: begin
          if (pend_q) begin
            cnt_n = rl_q; pend_n = 1'b0; ld_n = 1'b1; out_n = 1'b0;
          end else if (ld_q && gate) begin
            cnt_n = dec1;
            if (cnt_q == C_ONE) out_n = 1'b1;
          end
        end
        PM_TRIG_ONE: begin
          if (trig && have_q) begin
            cnt_n = rl_q; ld_n = 1'b1; out_n = 1'b0;
          end else if (ld_q) begin
            cnt_n = dec1;
            if (cnt_q == C_ONE) out_n = 1'b1;
          end
        end
        PM_RATE: begin
          if (pend_q) begin
            cnt_n = rl_q; pend_n = 1'b0; ld_n = 1'b1; out_n = 1'b1;
          end else if (ld_q && gate) begin
            if (cnt_q == C_ONE) begin
              cnt_n = rl_q; out_n = 1'b1;
            end else begin
              cnt_n = dec1;
              if (cnt_q == C_TWO) out_n = 1'b0;
            end
          end
        end
        PM_SQUARE: begin
          if (pend_q) begin
            cnt_n = rl_even; pend_n = 1'b0; ld_n = 1'b1; out_n = 1'b1;
          end else if (ld_q && gate) begin
            if (last_sq) begin
              cnt_n = rl_even; out_n = !out_q;
            end else begin
              cnt_n = dec2;
            end
          end
        end
        PM_SW_STRB: begin
          if (pend_q) begin
            cnt_n = rl_q; pend_n = 1'b0; ld_n = 1'b1; out_n = 1'b1; done_n = 1'b0;
          end else if (ld_q) begin
            if (!out_q) out_n = 1'b1;
            if (gate) begin
              cnt_n = dec1;
              if (cnt_q == C_ONE && !done_q) begin
                out_n = 1'b0; done_n = 1'b1;
              end
            end
          end
        end
        default: begin
          if (trig && have_q) begin
            cnt_n = rl_q; ld_n = 1'b1; out_n = 1'b1; done_n = 1'b0;
          end else if (ld_q) begin
            if (!out_q) out_n = 1'b1;
            cnt_n = dec1;
            if (cnt_q == C_ONE && !done_q) begin
              out_n = 1'b0; done_n = 1'b1;
            end
          end
        end
      endcase
    end
    if (!mode_wr && !gate && (mode_q == PM_RATE || mode_q == PM_SQUARE))
      out_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mode_q <= PM_TIMEOUT;
      bcd_q  <= 1'b0;
      rl_q   <= '0;
      cnt_q  <= '0;
      out_q  <= 1'b0;
      ld_q   <= 1'b0;
      have_q <= 1'b0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      mode_q <= mode_n;
      bcd_q  <= bcd_n;
      rl_q   <= rl_n;
      cnt_q  <= cnt_n;
      out_q  <= out_n;
      ld_q   <= ld_n;
      have_q <= have_n;
      pend_q <= pend_n;
      done_q <= done_n;
    end
  end

  assign count  = cnt_q;
  assign out    = out_q;
  assign loaded = ld_q;

  assert_timeout_stays_high_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode_q == PM_TIMEOUT && out_q && !mode_wr && !cnt_wr) |=> out_q);

  assert_rate_low_at_one_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode_q == PM_RATE && ld_q && !pend_q && gate && tick && !mode_wr && !cnt_wr &&
     cnt_q == C_TWO) |=> !out_q);

  assert_gate_forces_high_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((mode_q == PM_RATE || mode_q == PM_SQUARE) && !gate && !mode_wr) |=> out_q);

  assert_loaded_clear_R11: assert property (@(posedge clk) disable iff (!rst_s_n)
    mode_wr |=> !ld_q);

  assert_count_hold_R12: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!tick && !mode_wr && !cnt_wr) |=> $stable(cnt_q));
endmodule

// File: tb/tb_pit_channel.sv
module tb_pit_channel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, gate, mode_wr, bcd_sel, cnt_wr;
  logic [2:0]  mode_sel;
  logic [15:0] cnt_val;
  logic [15:0] count;
  logic        out, loaded;

  int errors = 0;
  int total  = 0;
  int cyc    = 0;
  logic tr [1:64];
  logic ex [1:64];

  pit_channel #(.CW(16)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate),
    .mode_wr(mode_wr), .mode_sel(mode_sel), .bcd_sel(bcd_sel),
    .cnt_wr(cnt_wr), .cnt_val(cnt_val),
    .count(count), .out(out), .loaded(loaded)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++; total++;
      $display("FAIL watchdog: actual=%0d expected<=190000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, total);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmp_trace(input string tag, input int n);
    int bad = 0;
    total++;
    for (int k = 1; k <= n; k++) begin
      if (bad == 0 && tr[k] !== ex[k]) begin
        bad = k;
        $display("FAIL %s: tick %0d actual=%0b expected=%0b", tag, k, tr[k], ex[k]);
      end
    end
    if (bad != 0) errors++;
  endtask

  // kind: 0 timeout, 2 rate, 3 square, 4 strobe
  function automatic logic f_exp(input int kind, input int k, input int n);
    case (kind)
      0: return k >= n + 1;
      2: return (k % n) != 0;
      3: return ((k - 1) % n) < ((n + 1) / 2);
      default: return k != n + 1;
    endcase
  endfunction

  task automatic fill_exp(input int kind, input int n, input int len);
    for (int k = 1; k <= len; k++) ex[k] = f_exp(kind, k, n);
  endtask

  function automatic logic [15:0] to_bcd(input int v);
    return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
  endfunction

  task automatic prog(input logic [2:0] m, input logic b);
    mode_wr = 1'b1; mode_sel = m; bcd_sel = b;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic wcount(input logic [15:0] v);
    cnt_wr = 1'b1; cnt_val = v;
    @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  task automatic run_trace(input int n, input int gk, input logic gv);
    tick = 1'b1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      tr[k] = out;
      if (k == gk) gate = gv;
    end
    tick = 1'b0;
  endtask

  task automatic run_until_rise(input int mx, output int found);
    found = -1;
    tick = 1'b1;
    for (int k = 1; k <= mx; k++) begin
      @(negedge clk);
      if (out && found < 0) begin
        found = k;
        break;
      end
    end
    tick = 1'b0;
  endtask

  initial begin
    int r, n;
    void'($urandom(32'd24681357));
    tick = 0; gate = 0; mode_wr = 0; mode_sel = 0; bcd_sel = 0; cnt_wr = 0; cnt_val = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 reset count", count, 0);
    chk("R12 reset out", out, 0);
    chk("R11 reset loaded", loaded, 0);

    // R1 mode 0 directed
    prog(3'd0, 1'b0);
    chk("R11 loaded after mode write", loaded, 0);
    gate = 1;
    wcount(16'd5);
    chk("R11 loaded before load tick", loaded, 0);
    run_trace(1, 0, 1'b0);
    chk("R11 loaded after load tick", loaded, 1);
    wcount(16'd5);
    run_trace(12, 0, 1'b0);
    fill_exp(0, 5, 12);
    cmp_trace("R1 timeout N=5", 12);
    // R1 gate low holds the count
    gate = 0;
    wcount(16'd3);
    run_trace(6, 0, 1'b0);
    chk("R1 gate low count held", count, 3);
    chk("R1 gate low out", out, 0);
    gate = 1;
    run_until_rise(20, r);
    chk("R1 rise after gate opens", r, 3);
    for (int i = 0; i < 5; i++) begin
      n = 2 + int'($urandom % 200);
      wcount(16'(n));
      run_until_rise(400, r);
      chk("R1 random timeout rise tick", r, n + 1);
    end
    // R12 hold without tick
    wcount(16'd20);
    run_trace(3, 0, 1'b0);
    repeat (5) @(negedge clk);
    chk("R12 count held without tick", count, 18);

    // R10 mode 0 restart
    wcount(16'd10);
    run_trace(5, 0, 1'b0);
    wcount(16'd3);
    run_trace(8, 0, 1'b0);
    fill_exp(0, 3, 8);
    cmp_trace("R10 timeout rewrite restarts", 8);

    // R2 mode 1
    gate = 0;
    prog(3'd1, 1'b0);
    wcount(16'd6);
    run_trace(4, 0, 1'b0);
    for (int k = 1; k <= 4; k++) ex[k] = 1'b1;
    cmp_trace("R2 idle high without trigger", 4);
    chk("R11 loaded before trigger", loaded, 0);
    gate = 1;
    run_trace(12, 2, 1'b0);
    fill_exp(0, 6, 12);
    cmp_trace("R2 triggered one-shot, gate dropped", 12);
    chk("R11 loaded after trigger", loaded, 1);
    gate = 1;
    run_trace(3, 0, 1'b0);
    gate = 0;
    @(negedge clk);
    gate = 1;
    @(negedge clk);
    run_trace(10, 0, 1'b0);
    fill_exp(0, 6, 10);
    cmp_trace("R2 retrigger restarts", 10);

    // R3 mode 2
    gate = 1;
    prog(3'd2, 1'b0);
    wcount(16'd4);
    run_trace(13, 0, 1'b0);
    fill_exp(2, 4, 13);
    cmp_trace("R3 rate N=4", 13);
    prog(3'd2, 1'b0);
    wcount(16'd5);
    run_trace(5, 0, 1'b0);
    chk("R3 low at count 1", out, 0);
    gate = 0;
    @(negedge clk);
    chk("R3 gate low forces high", out, 1);
    run_trace(4, 0, 1'b0);
    chk("R3 gate low holds count", count, 1);
    chk("R3 gate low keeps high", out, 1);
    gate = 1;
    for (int i = 0; i < 3; i++) begin
      n = 2 + int'($urandom % 14);
      prog(3'd2, 1'b0);
      wcount(16'(n));
      run_trace(40, 0, 1'b0);
      fill_exp(2, n, 40);
      cmp_trace("R3 random rate", 40);
    end
    // R10 mode 2 new count at next reload
    prog(3'd2, 1'b0);
    wcount(16'd4);
    run_trace(1, 0, 1'b0);
    wcount(16'd6);
    run_trace(16, 0, 1'b0);
    for (int k = 1; k <= 16; k++) ex[k] = !(k == 3 || (k > 3 && (k - 3) % 6 == 0));
    cmp_trace("R10 rate rewrite at reload", 16);

    // R4 mode 3
    prog(3'd3, 1'b0);
    wcount(16'd6);
    run_trace(30, 0, 1'b0);
    fill_exp(3, 6, 30);
    cmp_trace("R4 square even N=6", 30);
    prog(3'd3, 1'b0);
    wcount(16'd7);
    run_trace(30, 0, 1'b0);
    fill_exp(3, 7, 30);
    cmp_trace("R4 square odd N=7", 30);
    for (int i = 0; i < 4; i++) begin
      n = 2 + int'($urandom % 29);
      prog(3'd3, 1'b0);
      wcount(16'(n));
      run_trace(64, 0, 1'b0);
      fill_exp(3, n, 64);
      cmp_trace("R4 random square", 64);
    end

    // R5 mode 4
    prog(3'd4, 1'b0);
    wcount(16'd5);
    run_trace(15, 0, 1'b0);
    fill_exp(4, 5, 15);
    cmp_trace("R5 strobe N=5", 15);
    for (int i = 0; i < 2; i++) begin
      n = 2 + int'($urandom % 40);
      wcount(16'(n));
      run_trace(60, 0, 1'b0);
      fill_exp(4, n, 60);
      cmp_trace("R5 random strobe", 60);
    end
    wcount(16'd10);
    run_trace(4, 0, 1'b0);
    wcount(16'd3);
    run_trace(8, 0, 1'b0);
    fill_exp(4, 3, 8);
    cmp_trace("R10 strobe rewrite restarts", 8);

    // R6 mode 5
    gate = 0;
    prog(3'd5, 1'b0);
    wcount(16'd4);
    run_trace(5, 0, 1'b0);
    for (int k = 1; k <= 5; k++) ex[k] = 1'b1;
    cmp_trace("R6 idle high before trigger", 5);
    gate = 1;
    run_trace(12, 1, 1'b0);
    fill_exp(4, 4, 12);
    cmp_trace("R6 gate strobe, gate dropped", 12);

    // R7 BCD
    gate = 1;
    prog(3'd0, 1'b1);
    wcount(16'h0100);
    run_trace(2, 0, 1'b0);
    chk("R7 decimal borrow 0100->0099", count, 16'h0099);
    for (int i = 0; i < 3; i++) begin
      n = 2 + int'($urandom % 150);
      wcount(to_bcd(n));
      run_until_rise(400, r);
      chk("R7 random BCD timeout rise tick", r, n + 1);
    end
    prog(3'd3, 1'b1);
    wcount(16'h0010);
    run_trace(30, 0, 1'b0);
    fill_exp(3, 10, 30);
    cmp_trace("R7 BCD square N=10", 30);
    prog(3'd3, 1'b1);
    wcount(16'h0013);
    run_trace(40, 0, 1'b0);
    fill_exp(3, 13, 40);
    cmp_trace("R7 BCD square N=13", 40);

    // R8 aliases
    prog(3'd6, 1'b0);
    wcount(16'd3);
    run_trace(12, 0, 1'b0);
    fill_exp(2, 3, 12);
    cmp_trace("R8 code 6 as rate", 12);
    prog(3'd7, 1'b0);
    wcount(16'd5);
    run_trace(20, 0, 1'b0);
    fill_exp(3, 5, 20);
    cmp_trace("R8 code 7 as square", 20);

    // R9 zero reload
    prog(3'd0, 1'b0);
    wcount(16'd0);
    run_trace(2, 0, 1'b0);
    chk("R9 binary wrap", count, 16'hFFFF);
    wcount(16'd0);
    run_until_rise(70000, r);
    chk("R9 binary zero means 65536", r, 65537);
    prog(3'd0, 1'b1);
    wcount(16'd0);
    run_trace(2, 0, 1'b0);
    chk("R9 BCD wrap", count, 16'h9999);
    wcount(16'd0);
    run_until_rise(12000, r);
    chk("R9 BCD zero means 10000", r, 10001);

    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule